// File: doc/BRIEF.md
# Keyed Watchdog Reset Timer

This block guards a processor against a hung program. Once software sets its enable, a prescaled timebase counts towards a fixed timeout of 250 ms by default. If the timeout runs out, the block drives a reset pulse of fixed length. Only one byte value (0x5A) written to the hold-off port restarts the timeout. Every other byte is ignored, so a runaway loop that scribbles random data is unlikely to keep the system alive by accident.

The timeout is set by parameters and not by software. A clock-frequency parameter and a tick-rate parameter give the prescaler length. A timeout in milliseconds gives the number of ticks. A simulation can therefore use a short period. When the timeout expires, the enable drops at the same clock edge at which the pulse starts. This matches the enable being cleared by the system reset that follows. Enable writes made while the pulse is in progress are ignored.

Top module: `wdt_keyed`

## Requirements
- R1: After a synchronous reset, `wd_enabled` and `wd_reset` are both 0. A reset in the middle of a period cancels it, and no pulse follows.
- R2: An enable write with `ctl_en`=1 while disabled starts a fresh period. `wd_reset` first reads 1 exactly N clock edges after the edge that captured the write, where N = (CLK_HZ/TICK_HZ) * (TIMEOUT_MS*TICK_HZ/1000).
- R3: A hold-off write of 0x5A while enabled restarts the period, and `wd_reset` then rises N edges after the capturing edge. A key captured on the very edge on which the timeout would expire still prevents the pulse.
- R4: A hold-off write of any byte other than 0x5A has no effect on when the pulse occurs.
- R5: An enable write with `ctl_en`=0 stops the watchdog, and no pulse occurs while it is disabled. A later enable runs a full N-cycle period.
- R6: An enable write with `ctl_en`=1 while already enabled does not restart or shorten the period.
- R7: On timeout, `wd_reset` stays 1 for exactly PULSE_CYC consecutive cycles. `wd_enabled` reads 0 from the same edge on which `wd_reset` rises.
- R8: Enable writes made while `wd_reset` is 1 are ignored, and the block stays disabled after the pulse.
- R9: Hold-off writes (including 0x5A) made while disabled have no effect. A subsequent enable still runs a full N-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the enable bit |
| ctl_en | input | 1 | Enable value written with `ctl_wr` (1 enables, 0 disables) |
| hold_wr | input | 1 | Write strobe for the hold-off byte |
| hold_data | input | 8 | Hold-off byte; 0x5A is the restart key |
| wd_enabled | output | 1 | Watchdog is armed and counting |
| wd_reset | output | 1 | Reset pulse, high for PULSE_CYC cycles on timeout |

## Verification
The hardest cases to reach from the ports are the key arriving on the same edge as the expiry, and a non-key byte arriving at each point of a period. A small configuration makes a period 40 cycles long. The stimulus then sweeps the key over every capture edge from the first to the expiry edge itself, and streams all 255 non-key bytes through successive periods, one per cycle. Each run measures the edge at which the pulse rises and the pulse length, and compares them with values derived arithmetically from the capture edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] WDT_KEY = 8'h5A;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic key_hit;
    } wd_cmd_t;

    function automatic int unsigned prescale_len(input int unsigned clk_hz,
                                                 input int unsigned tick_hz);
        return clk_hz / tick_hz;
    endfunction

    function automatic int unsigned period_ticks(input int unsigned ms,
                                                 input int unsigned tick_hz);
        return (ms * tick_hz) / 1000;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned PRE_DIV = 8,
    parameter int unsigned PRE_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt
);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (run) begin
            if (pre_q == PRE_LAST) pre_q <= '0;
            else                   pre_q <= pre_q + 1'b1;
        end
    end

    assign tick    = run && (pre_q == PRE_LAST);
    assign pre_cnt = pre_q;
endmodule

// File: rtl/wdt_period.sv
module wdt_period #(
    parameter int unsigned TICKS = 5,
    parameter int unsigned TK_W  = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            tick,
    output logic            last,
    output logic [TK_W-1:0] tk_cnt
);
    localparam logic [TK_W-1:0] TK_LAST = TK_W'(TICKS - 1);

    logic [TK_W-1:0] tk_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tk_q <= '0;
        end else if (tick) begin
            tk_q <= tk_q + 1'b1;
        end
    end

    assign last   = tick && (tk_q == TK_LAST);
    assign tk_cnt = tk_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_CYC = 16,
    parameter int unsigned PW       = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic busy
);
    logic [PW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (fire) begin
            pc_q <= PW'(PULSE_CYC);
        end else if (pc_q != '0) begin
            pc_q <= pc_q - 1'b1;
        end
    end

    assign busy = (pc_q != '0);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic       ctl_en,
    input  logic       hold_wr,
    input  logic [7:0] hold_data,
    input  logic       period_last,
    input  logic       pulse_busy,
    output logic       run,
    output logic       cnt_clr,
    output logic       fire
);
    wd_state_e state_q, state_d;
    wd_cmd_t   cmd;

    always_comb begin
        cmd.en_set  = ctl_wr && ctl_en;
        cmd.en_clr  = ctl_wr && !ctl_en;
        cmd.key_hit = hold_wr && (hold_data == WDT_KEY) && (state_q == WD_RUN);
    end

    assign fire = (state_q == WD_RUN) && !cmd.en_clr && !cmd.key_hit && period_last;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (cmd.en_set)  state_d = WD_RUN;
            WD_RUN: begin
                if (cmd.en_clr)       state_d = WD_OFF;
                else if (fire)        state_d = WD_FIRE;
            end
            WD_FIRE: if (!pulse_busy) state_d = WD_OFF;
            default:                  state_d = WD_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WD_OFF;
        else     state_q <= state_d;
    end

    assign run     = (state_q == WD_RUN);
    assign cnt_clr = cmd.key_hit || (run && cmd.en_clr) || fire;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TICK_HZ    = 1000,
    parameter int unsigned TIMEOUT_MS = 250,
    parameter int unsigned PULSE_CYC  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_wr,
    input  logic       ctl_en,
    input  logic       hold_wr,
    input  logic [7:0] hold_data,
    output logic       wd_enabled,
    output logic       wd_reset
);
    localparam int unsigned PRE_DIV = prescale_len(CLK_HZ, TICK_HZ);
    localparam int unsigned TICKS   = period_ticks(TIMEOUT_MS, TICK_HZ);
    localparam int unsigned PRE_W   = cnt_width(PRE_DIV);
    localparam int unsigned TK_W    = cnt_width(TICKS + 1);
    localparam int unsigned PW      = cnt_width(PULSE_CYC + 1);

    logic             run, cnt_clr, fire, tick, period_last, pulse_busy;
    logic [PRE_W-1:0] pre_cnt;
    logic [TK_W-1:0]  tk_cnt;

    wdt_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_en     (ctl_en),
        .hold_wr    (hold_wr),
        .hold_data  (hold_data),
        .period_last(period_last),
        .pulse_busy (pulse_busy),
        .run        (run),
        .cnt_clr    (cnt_clr),
        .fire       (fire)
    );

    wdt_prescaler #(.PRE_DIV(PRE_DIV), .PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .clr    (cnt_clr),
        .tick   (tick),
        .pre_cnt(pre_cnt)
    );

    wdt_period #(.TICKS(TICKS), .TK_W(TK_W)) u_per (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .tick  (tick),
        .last  (period_last),
        .tk_cnt(tk_cnt)
    );

    wdt_pulse #(.PULSE_CYC(PULSE_CYC), .PW(PW)) u_pls (
        .clk (clk),
        .rst (rst),
        .fire(fire),
        .busy(pulse_busy)
    );

    assign wd_enabled = run;
    assign wd_reset   = pulse_busy;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
    parameter int unsigned PULSE_CYC = 64,
    parameter int unsigned PRE_W     = 16,
    parameter int unsigned TK_W      = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hold_wr,
    input logic [7:0]       hold_data,
    input logic             wd_enabled,
    input logic             wd_reset,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [TK_W-1:0]  tk_cnt
);
    localparam int unsigned HW = $clog2(PULSE_CYC + 2) + 1;

    logic [HW-1:0] hi_cnt;
    logic          rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)           hi_cnt <= '0;
        else if (wd_reset) hi_cnt <= hi_cnt + 1'b1;
        else               hi_cnt <= '0;
    end

    // R5: counters parked at zero whenever the watchdog is not armed
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !wd_enabled |-> (pre_cnt == '0 && tk_cnt == '0));

    // R5: no pulse can start while disarmed
    a_r5_no_pulse_off: assert property (@(posedge clk) disable iff (rst)
        (!wd_enabled && !wd_reset) |=> !wd_reset);

    // R2: arming always begins from an empty count
    a_r2_fresh_start: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_enabled) |-> (pre_cnt == '0 && tk_cnt == '0));

    // R3: the key restarts the count
    a_r3_key_restart: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && hold_data == 8'h5A && wd_enabled) |=> (pre_cnt == '0 && tk_cnt == '0));

    // R7: enable drops as the pulse begins
    a_r7_enable_drops: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> !wd_enabled);

    // R7: pulse length
    a_r7_pulse_len: assert property (@(posedge clk) disable iff (rst)
        ($fell(wd_reset) && !rst_d) |-> (hi_cnt == HW'(PULSE_CYC)));

    // R8: nothing re-arms during the pulse
    a_r8_no_rearm: assert property (@(posedge clk) disable iff (rst)
        wd_reset |=> !wd_enabled);
endmodule

bind wdt_keyed wdt_keyed_chk #(
    .PULSE_CYC(PULSE_CYC),
    .PRE_W    (PRE_W),
    .TK_W     (TK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold_wr   (hold_wr),
    .hold_data (hold_data),
    .wd_enabled(wd_enabled),
    .wd_reset  (wd_reset),
    .pre_cnt   (pre_cnt),
    .tk_cnt    (tk_cnt)
);

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
    localparam int CLK_HZ     = 8000;
    localparam int TICK_HZ    = 1000;
    localparam int TIMEOUT_MS = 5;
    localparam int PULSE_CYC  = 6;
    localparam int N          = (CLK_HZ / TICK_HZ) * ((TIMEOUT_MS * TICK_HZ) / 1000);
    localparam int LIMIT      = 2 * N + PULSE_CYC + 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0, ctl_en = 1'b0, hold_wr = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic       wd_enabled, wd_reset;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    wdt_keyed #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ),
        .TIMEOUT_MS(TIMEOUT_MS), .PULSE_CYC(PULSE_CYC)
    ) u_wdt_keyed (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .hold_wr(hold_wr), .hold_data(hold_data),
        .wd_enabled(wd_enabled), .wd_reset(wd_reset)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_en(input logic v);
        ctl_wr = 1'b1; ctl_en = v;
        cyc();
        ctl_wr = 1'b0; ctl_en = 1'b0;
    endtask

    // Runs from the current negedge; stimulus chosen per iteration c is
    // captured at relative edge c. rise = first relative edge with wd_reset high.
    task automatic run_measure(input int junk_base, input int key_at, input int reen_at,
                               output int rise, output int width);
        rise = -1; width = 0;
        for (int c = 1; c <= LIMIT; c++) begin
            int v;
            hold_wr = 1'b0; ctl_wr = 1'b0; ctl_en = 1'b0;
            v = junk_base + c - 1;
            if (junk_base >= 0 && c <= N - 1 && v <= 255 && v != 8'h5A) begin
                hold_wr = 1'b1; hold_data = 8'(v);
            end
            if (key_at == c) begin
                hold_wr = 1'b1; hold_data = 8'h5A;
            end
            if (reen_at == c) begin
                ctl_wr = 1'b1; ctl_en = 1'b1;
            end
            cyc();
            if (wd_reset) begin
                if (rise < 0) rise = c;
                width++;
            end
        end
        hold_wr = 1'b0; ctl_wr = 1'b0; ctl_en = 1'b0;
    endtask

    initial begin
        #400_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rise, width;
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cyc();
        check("R1 reset enabled", wd_enabled, 0);
        check("R1 reset pulse", wd_reset, 0);

        // R2 / R7: plain timeout
        write_en(1'b1);
        check("R2 armed", wd_enabled, 1);
        run_measure(-1, -1, -1, rise, width);
        check("R2 rise edge", rise, N);
        check("R7 pulse width", width, PULSE_CYC);
        check("R7 enable cleared", wd_enabled, 0);

        // R3: key at every capture edge, including the expiry edge
        for (int k = 1; k <= N; k++) begin
            write_en(1'b1);
            run_measure(-1, k, -1, rise, width);
            check($sformatf("R3 key at %0d rise", k), rise, k + N);
            check($sformatf("R3 key at %0d width", k), width, PULSE_CYC);
        end

        // R4: every non-key byte streamed through successive periods
        for (int b = 0; b < 256; b += N - 1) begin
            write_en(1'b1);
            run_measure(b, -1, -1, rise, width);
            check($sformatf("R4 junk from %0d rise", b), rise, N);
            check($sformatf("R4 junk from %0d width", b), width, PULSE_CYC);
        end

        // R5: disable stops it; re-enable gives a full period
        write_en(1'b1);
        for (int i = 0; i < 20; i++) cyc();
        write_en(1'b0);
        check("R5 disabled", wd_enabled, 0);
        run_measure(-1, -1, -1, rise, width);
        check("R5 no pulse while off", rise, -1);
        write_en(1'b1);
        run_measure(-1, -1, -1, rise, width);
        check("R5 re-enable full period", rise, N);

        // R6: re-writing enable while armed has no effect
        write_en(1'b1);
        run_measure(-1, -1, 20, rise, width);
        check("R6 rewrite enable rise", rise, N);

        // R9: key while disabled does nothing
        for (int i = 0; i < 3; i++) begin
            hold_wr = 1'b1; hold_data = 8'h5A; cyc();
        end
        hold_wr = 1'b0;
        check("R9 still off", wd_enabled, 0);
        check("R9 no pulse", wd_reset, 0);
        write_en(1'b1);
        run_measure(-1, -1, -1, rise, width);
        check("R9 full period after", rise, N);

        // R8: enable write during pulse ignored
        write_en(1'b1);
        for (int i = 0; i < N; i++) cyc();
        check("R8 pulse active", wd_reset, 1);
        write_en(1'b1);
        for (int i = 0; i < PULSE_CYC + 3; i++) cyc();
        check("R8 stays disabled", wd_enabled, 0);
        check("R8 pulse over", wd_reset, 0);

        // R1: reset mid-period cancels it
        write_en(1'b1);
        for (int i = 0; i < 10; i++) cyc();
        rst = 1'b1; cyc(); rst = 1'b0;
        check("R1 mid reset enabled", wd_enabled, 0);
        run_measure(-1, -1, -1, rise, width);
        check("R1 no pulse after reset", rise, -1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule